// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital sequencer of a hot-swap controller. It decides when the external pass transistor may be switched on, how long an overcurrent may last before the attempt is abandoned, and what happens after such a fault. One up/down counter stands in for the timing capacitor. It rises at a slow rate or at a fault rate, and it falls at a fast rate or at a slow rate. Two counter thresholds, set in a 1.3 : 0.2 ratio, bound every interval. So the power-up delay, the overcurrent allowance and the retry cool-down keep their relative lengths.

The block has inputs for supply-good, an enable pin of selectable polarity and a software-off bit. It also has the outputs of two current comparators: one that starts fault timing and one that trips at once. It drives a gate enable, a select for pull-down strength and a timed-fault flag. A parameter chooses between automatic retry and latch-off after a timed fault. No data stream flows through the block, so every pin is a plain level with no handshake.

Top module: `hsc_core`

## Requirements
- R1: While `supply_ok` is low, the block enters its reset state at the next clock edge: `gate_en`=0, `pd_strong`=1, `oc_fault`=0 and the counter cleared. When `supply_ok` returns, the power-up delay starts again from the beginning.
- R2: After `supply_ok` rises, the counter climbs by 5 per cycle until it reaches 1300, then falls by 100 per cycle until it is at or below 200. The gate stays off for this whole delay. With enable already asserted, `gate_en` first reads 1 after the 273rd clock edge following the rise of `supply_ok`.
- R3: Once the delay is done, the clock edge that sees the filtered enable active and `sw_off`=0 starts a swap, and `gate_en` goes to 1. The first edge that sees either condition removed ends the swap: `gate_en`=0 and the counter discharges by 100 per cycle.
- R4: During a swap, the counter rises by 50 per cycle while `oc_timing` is high and falls by 100 per cycle while it is low. If `oc_timing` drops before 1300 is reached, the gate stays on and no fault is flagged. Starting from an empty counter, a constant overcurrent is flagged after 26 edges.
- R5: When the counter reaches 1300 during a swap, the swap ends at that same edge with `gate_en`=0, `pd_strong`=0 (weak pull-down) and `oc_fault`=1.
- R6: With `AUTO_RETRY`=0, the block stays off with `oc_fault`=1 after a timed fault, whatever the comparators do. Only a de-assertion of the filtered enable (which clears `oc_fault`) followed by a new assertion starts another swap.
- R7: With `AUTO_RETRY`=1, the counter falls by 2 per cycle after a timed fault. The swap restarts at the edge where it reaches 200 or below, and `oc_fault` returns to 0. Under a constant overcurrent this gives 550 cycles off and 22 cycles on, an on-time share near 3.8 %.
- R8: `oc_fast`=1 forces `gate_en` to 0 in the same cycle, with no timing and no change of sequencer state. The gate comes back on when `oc_fast` falls, as long as the swap is still running.
- R9: The enable pin is active high when `EN_ACT_HIGH`=1 and active low when it is 0. A change is accepted only after `FILT_CYC` (default 4) consecutive clock edges that all see the new level. Shorter pulses have no effect on `gate_en`.
- R10: `pd_strong` is 1 only in the reset state. Every other gate-off condition selects the weak pull-down (`pd_strong`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag; low holds the block in reset |
| en_pin | input | 1 | Enable pin, polarity set by `EN_ACT_HIGH` |
| sw_off | input | 1 | Software request to turn the gate off |
| oc_timing | input | 1 | Overcurrent comparator that starts fault timing |
| oc_fast | input | 1 | Severe overcurrent comparator, acts at once |
| gate_en | output | 1 | Gate drive enable |
| pd_strong | output | 1 | Pull-down strength select: 1 strong, 0 weak |
| oc_fault | output | 1 | Off because of a timed overcurrent fault |

## Verification
The assertions assume that every input is already synchronous to `clk`: the block samples its inputs directly, and no synchronizer is provided at its edge. They also assume that 1300 plus the largest rising step fits in the counter. The stimulus changes inputs only on the falling clock edge and keeps the default counter width, so both assumptions hold. It uses the two enable polarities in complementary form, so the retry instance and the latch-off instance see the same logical enable. Long overcurrent runs are held steady, so that the lengths of the cool-down and on-time can be measured run by run.

// File: rtl/hsc_pkg.sv
`timescale 1ns / 1ps
package hsc_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_INIT_UP,
    ST_INIT_DN,
    ST_IDLE,
    ST_SWAP,
    ST_COOL,
    ST_LATCH
  } hsc_state_e;

  typedef enum logic [2:0] {
    TM_CLEAR,
    TM_UP_SLOW,
    TM_UP_FAULT,
    TM_DN_FAST,
    TM_DN_SLOW
  } hsc_tmode_e;

endpackage

// File: rtl/hsc_en_filter.sv
`timescale 1ns / 1ps
module hsc_en_filter #(
  parameter bit          ACT_HIGH = 1'b1,
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pin,
  output logic en_q
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic          raw;
  logic [CW-1:0] run_q;

  generate
    if (ACT_HIGH) begin : g_pol_high
      assign raw = pin;
    end else begin : g_pol_low
      assign raw = ~pin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= '0;
    end else if (clr) begin
      en_q  <= 1'b0;
      run_q <= '0;
    end else if (raw == en_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_CYC - 1)) begin
      en_q  <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(en_q) && !$past(clr)) |-> (en_q == $past(raw))); // R9

endmodule

// File: rtl/hsc_ramp_timer.sv
`timescale 1ns / 1ps
module hsc_ramp_timer
  import hsc_pkg::*;
#(
  parameter int unsigned TMR_W    = 12,
  parameter int unsigned UP_INIT  = 5,
  parameter int unsigned UP_FAULT = 50,
  parameter int unsigned DN_FAST  = 100,
  parameter int unsigned DN_SLOW  = 2,
  parameter int unsigned TH_HI    = 1300,
  parameter int unsigned TH_LO    = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hsc_tmode_e       mode,
  output logic [TMR_W-1:0] cnt_q,
  output logic             hit_hi,
  output logic             hit_lo
);
  localparam logic [TMR_W-1:0] K_UP_INIT  = TMR_W'(UP_INIT);
  localparam logic [TMR_W-1:0] K_UP_FAULT = TMR_W'(UP_FAULT);
  localparam logic [TMR_W-1:0] K_DN_FAST  = TMR_W'(DN_FAST);
  localparam logic [TMR_W-1:0] K_DN_SLOW  = TMR_W'(DN_SLOW);
  localparam logic [TMR_W-1:0] K_TH_HI    = TMR_W'(TH_HI);
  localparam logic [TMR_W-1:0] K_TH_LO    = TMR_W'(TH_LO);

  logic [TMR_W:0]   wide;
  logic [TMR_W-1:0] cnt_nxt;

  always_comb begin
    case (mode)
      TM_CLEAR:    wide = '0;
      TM_UP_SLOW:  wide = {1'b0, cnt_q} + {1'b0, K_UP_INIT};
      TM_UP_FAULT: wide = {1'b0, cnt_q} + {1'b0, K_UP_FAULT};
      TM_DN_FAST:  wide = (cnt_q < K_DN_FAST) ? '0 : {1'b0, cnt_q - K_DN_FAST};
      TM_DN_SLOW:  wide = (cnt_q < K_DN_SLOW) ? '0 : {1'b0, cnt_q - K_DN_SLOW};
      default:     wide = {1'b0, cnt_q};
    endcase
    cnt_nxt = wide[TMR_W] ? '1 : wide[TMR_W-1:0];
  end

  assign hit_hi = (cnt_nxt >= K_TH_HI);
  assign hit_lo = (cnt_nxt <= K_TH_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/hsc_seq_fsm.sv
`timescale 1ns / 1ps
module hsc_seq_fsm
  import hsc_pkg::*;
#(
  parameter bit AUTO_RETRY = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       on_req,
  input  logic       oc_timing,
  input  logic       hit_hi,
  input  logic       hit_lo,
  output hsc_state_e state_q,
  output hsc_tmode_e tmode
);
  localparam hsc_state_e FAULT_ST = AUTO_RETRY ? ST_COOL : ST_LATCH;

  hsc_state_e st_nxt;

  always_comb begin
    st_nxt = state_q;
    tmode  = TM_DN_FAST;
    case (state_q)
      ST_RESET: begin
        tmode  = TM_CLEAR;
        st_nxt = ST_INIT_UP;
      end
      ST_INIT_UP: begin
        tmode = TM_UP_SLOW;
        if (hit_hi) st_nxt = ST_INIT_DN;
      end
      ST_INIT_DN: if (hit_lo) st_nxt = ST_IDLE;
      ST_IDLE:    if (on_req) st_nxt = ST_SWAP;
      ST_SWAP: begin
        tmode = oc_timing ? TM_UP_FAULT : TM_DN_FAST;
        if (!on_req)     st_nxt = ST_IDLE;
        else if (hit_hi) st_nxt = FAULT_ST;
      end
      ST_COOL: begin
        tmode = TM_DN_SLOW;
        if (!on_req)     st_nxt = ST_IDLE;
        else if (hit_lo) st_nxt = ST_SWAP;
      end
      ST_LATCH:   if (!on_req) st_nxt = ST_IDLE;
      default:    st_nxt = ST_RESET;
    endcase
    if (!supply_ok) st_nxt = ST_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= st_nxt;
  end

  AST_FAULT_FROM_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_COOL || state_q == ST_LATCH) |-> ($past(state_q) == ST_SWAP)); // R5

endmodule

// File: rtl/hsc_core.sv
`timescale 1ns / 1ps
module hsc_core
  import hsc_pkg::*;
#(
  parameter int unsigned TMR_W       = 12,
  parameter int unsigned UP_INIT     = 5,
  parameter int unsigned UP_FAULT    = 50,
  parameter int unsigned DN_FAST     = 100,
  parameter int unsigned DN_SLOW     = 2,
  parameter int unsigned TH_HI       = 1300,
  parameter int unsigned TH_LO       = 200,
  parameter int unsigned FILT_CYC    = 4,
  parameter bit          AUTO_RETRY  = 1'b1,
  parameter bit          EN_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic en_pin,
  input  logic sw_off,
  input  logic oc_timing,
  input  logic oc_fast,
  output logic gate_en,
  output logic pd_strong,
  output logic oc_fault
);
  localparam int unsigned UP_MAX = (UP_INIT > UP_FAULT) ? UP_INIT : UP_FAULT;

  logic             en_f;
  logic             on_req;
  logic             hit_hi;
  logic             hit_lo;
  logic [TMR_W-1:0] tmr_cnt;
  hsc_state_e       st;
  hsc_tmode_e       tmode;

  hsc_en_filter #(
    .ACT_HIGH (EN_ACT_HIGH),
    .FILT_CYC (FILT_CYC)
  ) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~supply_ok),
    .pin   (en_pin),
    .en_q  (en_f)
  );

  assign on_req = en_f & ~sw_off;

  hsc_ramp_timer #(
    .TMR_W    (TMR_W),
    .UP_INIT  (UP_INIT),
    .UP_FAULT (UP_FAULT),
    .DN_FAST  (DN_FAST),
    .DN_SLOW  (DN_SLOW),
    .TH_HI    (TH_HI),
    .TH_LO    (TH_LO)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (tmode),
    .cnt_q  (tmr_cnt),
    .hit_hi (hit_hi),
    .hit_lo (hit_lo)
  );

  hsc_seq_fsm #(
    .AUTO_RETRY (AUTO_RETRY)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .on_req    (on_req),
    .oc_timing (oc_timing),
    .hit_hi    (hit_hi),
    .hit_lo    (hit_lo),
    .state_q   (st),
    .tmode     (tmode)
  );

  assign gate_en   = (st == ST_SWAP) & ~oc_fast;
  assign pd_strong = (st == ST_RESET);
  assign oc_fault  = (st == ST_COOL) | (st == ST_LATCH);

  AST_UVLO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pd_strong && !gate_en && !oc_fault)); // R1

  AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> $past(en_f && !sw_off)); // R3

  AST_TIMER_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tmr_cnt) < int'(TH_HI + UP_MAX))); // R5

endmodule

// File: tb/hsc_core_bench.sv
`timescale 1ns / 1ps
module hsc_core_bench;

  localparam int M_UP_I = 5;
  localparam int M_UP_F = 50;
  localparam int M_DN_F = 100;
  localparam int M_DN_S = 2;
  localparam int M_HI   = 1300;
  localparam int M_LO   = 200;
  localparam int M_FILT = 4;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0, en = 1'b0;
  logic sw_off = 1'b0, oc_t = 1'b0, oc_f = 1'b0;
  logic g0, p0, f0, g1, p1, f1;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;
  int ms[2], mc[2], mf[2], mr[2];
  int run = 0, last_on = 0, last_off = 0;
  logic prevg = 1'b0;

  always #2.5 clk = ~clk;

  hsc_core u_hsc_core (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en), .sw_off(sw_off),
    .oc_timing(oc_t), .oc_fast(oc_f), .gate_en(g0), .pd_strong(p0), .oc_fault(f0));

  hsc_core #(.AUTO_RETRY(1'b0), .EN_ACT_HIGH(1'b0)) u_hsc_core_latch (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(~en), .sw_off(sw_off),
    .oc_timing(oc_t), .oc_fast(oc_f), .gate_en(g1), .pd_strong(p1), .oc_fault(f1));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int s);
    case (s)
      0:       return "R1";
      1, 2:    return "R2";
      3:       return "R3";
      5:       return "R6";
      6:       return "R7";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference: states 0 reset,1 rise,2 fall,3 idle,4 on,5 latched,6 cooling
  task automatic step(int v);
    int st, nx, nst;
    bit req, hi, lo;
    st  = ms[v];
    req = (mf[v] != 0) && !sw_off;
    if (!supply_ok) begin mf[v] = 0; mr[v] = 0; end
    else if (int'(en) == mf[v]) mr[v] = 0;
    else if (mr[v] == M_FILT - 1) begin mf[v] = int'(en); mr[v] = 0; end
    else mr[v]++;
    case (st)
      0:       nx = 0;
      1:       nx = mc[v] + M_UP_I;
      4:       nx = oc_t ? mc[v] + M_UP_F : ((mc[v] > M_DN_F) ? mc[v] - M_DN_F : 0);
      6:       nx = (mc[v] > M_DN_S) ? mc[v] - M_DN_S : 0;
      default: nx = (mc[v] > M_DN_F) ? mc[v] - M_DN_F : 0;
    endcase
    hi  = nx >= M_HI;
    lo  = nx <= M_LO;
    nst = st;
    case (st)
      0: nst = 1;
      1: if (hi) nst = 2;
      2: if (lo) nst = 3;
      3: if (req) nst = 4;
      4: if (!req) nst = 3; else if (hi) nst = (v == 0) ? 6 : 5;
      5: if (!req) nst = 3;
      6: if (!req) nst = 3; else if (lo) nst = 4;
      default: nst = 0;
    endcase
    if (!supply_ok) nst = 0;
    ms[v] = nst;
    mc[v] = nx;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin ms[v] = 0; mc[v] = 0; mf[v] = 0; mr[v] = 0; end
    end else begin
      for (int v = 0; v < 2; v++) step(v);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int v = 0; v < 2; v++) begin
        logic ag, ap, af;
        bit eg, ep, ef;
        ag = (v == 0) ? g0 : g1;
        ap = (v == 0) ? p0 : p1;
        af = (v == 0) ? f0 : f1;
        eg = (ms[v] == 4) && !oc_f;
        ep = (ms[v] == 0);
        ef = (ms[v] == 5) || (ms[v] == 6);
        chk(ag === eg, (ms[v] == 4 && oc_f) ? "R8" : req_of(ms[v]), "gate_en", int'(ag), int'(eg));
        chk(ap === ep, "R10", "pd_strong", int'(ap), int'(ep));
        chk(af === ef, (ms[v] == 5) ? "R6" : "R5", "oc_fault", int'(af), int'(ef));
      end
      if (g0 === prevg) run++;
      else begin
        if (prevg) last_on = run; else last_off = run;
        run   = 1;
        prevg = g0;
      end
      cyc++;
      if (cyc > 150000) begin
        n_err++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(g0 == 0 && g1 == 0, "R1", "gate in reset", int'(g0), 0);
    chk(p0 == 1 && p1 == 1, "R10", "strong pull-down in reset", int'(p0), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p0 == 1 && g0 == 0 && f0 == 0, "R1", "held with supply low", int'(p0), 1);

    supply_ok = 1'b1; en = 1'b1; n = 0;
    while (!g0 && n < 400) begin @(negedge clk); n++; end
    chk(n == 273, "R2", "edges to first gate-on", n, 273);
    chk(g1 == 1, "R2", "latch variant gate-on", int'(g1), 1);
    chk(p0 == 0, "R10", "weak select after reset", int'(p0), 0);

    oc_t = 1'b1; repeat (10) @(negedge clk);
    chk(g0 == 1 && f0 == 0, "R4", "gate on during short overcurrent", int'(g0), 1);
    oc_t = 1'b0; repeat (20) @(negedge clk);
    chk(g0 == 1 && f0 == 0, "R4", "gate on after overcurrent ends", int'(g0), 1);

    oc_f = 1'b1; #1;
    chk(g0 == 0 && g1 == 0, "R8", "fast trip same cycle", int'(g0), 0);
    repeat (3) @(negedge clk);
    oc_f = 1'b0; #1;
    chk(g0 == 1 && f0 == 0, "R8", "gate back after fast trip", int'(g0), 1);

    @(negedge clk); en = 1'b0; repeat (2) @(negedge clk); en = 1'b1;
    repeat (6) @(negedge clk);
    chk(g0 == 1 && g1 == 1, "R9", "short enable pulse ignored", int'(g0), 1);
    en = 1'b0; repeat (6) @(negedge clk);
    chk(g0 == 0 && g1 == 0, "R9", "long enable drop accepted", int'(g0), 0);
    en = 1'b1; repeat (6) @(negedge clk);
    chk(g0 == 1 && g1 == 1, "R9", "enable re-accepted", int'(g0), 1);

    sw_off = 1'b1; @(negedge clk);
    chk(g0 == 0, "R3", "software off", int'(g0), 0);
    sw_off = 1'b0; @(negedge clk);
    chk(g0 == 1, "R3", "software off released", int'(g0), 1);

    repeat (20) @(negedge clk);
    oc_t = 1'b1; n = 0;
    while (!f0 && n < 100) begin @(negedge clk); n++; end
    chk(n == 26, "R4", "edges to timed fault from empty", n, 26);
    chk(g0 == 0 && p0 == 0, "R5", "weak pull-down after fault", int'(p0), 0);
    chk(f1 == 1 && g1 == 0, "R5", "latch variant fault", int'(f1), 1);

    n = 0;
    while (!g0 && n < 2000) begin @(negedge clk); n++; end
    chk(last_off == 550, "R7", "cool-down length", last_off, 550);
    chk(f0 == 0, "R7", "flag clears on retry", int'(f0), 0);
    n = 0;
    while (g0 && n < 100) begin @(negedge clk); n++; end
    chk(last_on == 22, "R7", "retry on-time", last_on, 22);
    n = last_on * 1000 / (last_on + last_off);
    chk(n >= 36 && n <= 40, "R7", "duty in permille", n, 38);
    chk(g1 == 0 && f1 == 1, "R6", "latched while overcurrent continues", int'(f1), 1);

    oc_t = 1'b0; repeat (600) @(negedge clk);
    chk(g1 == 0 && f1 == 1, "R6", "latched after overcurrent ends", int'(f1), 1);
    chk(g0 == 1, "R7", "retry variant back on", int'(g0), 1);
    en = 1'b0; repeat (6) @(negedge clk);
    chk(f1 == 0 && g1 == 0, "R6", "flag cleared by enable drop", int'(f1), 0);
    en = 1'b1; repeat (6) @(negedge clk);
    chk(g1 == 1, "R6", "swap after re-enable", int'(g1), 1);

    supply_ok = 1'b0; @(negedge clk);
    chk(g0 == 0 && p0 == 1 && f0 == 0, "R1", "supply drop", int'(p0), 1);
    chk(g1 == 0 && p1 == 1, "R1", "supply drop latch variant", int'(p1), 1);
    supply_ok = 1'b1; repeat (5) @(negedge clk);
    chk(g0 == 0 && p0 == 0, "R1", "delay restarts", int'(g0), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule